// File: doc/BRIEF.md
# Per-Timeslot Payload Conditioning Unit

This block sits in an E1 transmit path. The payload reaches it one 8-bit timeslot at a time, and each byte comes with a 5-bit timeslot index. For every timeslot the block keeps a control byte and an 8-bit trunk conditioning code. Software writes both through an indirect address/data port. For each byte, the block picks a replacement source: the byte unchanged, the timeslot's trunk code, an A-law or mu-law digital milliwatt sequence, or a loopback byte from the receive side. It then flips chosen bit positions with an XOR mask. The result appears one clock later, together with its valid flag and timeslot index.

A global substitution field can force the same replacement onto every timeslot. When that field is zero, each timeslot follows its own selector. The milliwatt sequences are eight bytes long. They step once per frame, and a valid byte on timeslot 0 marks the start of a new frame.

Top module: `tsc_payload_cond`

## Requirements
- R1: After reset every control byte and every trunk code reads back as 00h, out_valid is low and out_data is 00h.
- R2: A write at indirect address n (00h..1Fh) sets the control byte of timeslot n. A write at 20h+n sets the trunk code of timeslot n. A read at either address returns the stored value on cfg_rdata in the same cycle.
- R3: A write at address 40h or above leaves every stored byte unchanged, and a read at such an address returns 00h.
- R4: An input byte with in_valid high appears on out_data one clock later, with out_valid high and out_ts equal to its timeslot index. A cycle with in_valid low gives out_valid low in the next cycle.
- R5: Control bits 7:5 hold the substitution code. Code 000 outputs the input byte unchanged. The reserved codes 101, 110 and 111 also output the input byte unchanged.
- R6: Code 001 replaces the byte with the trunk code stored for that timeslot.
- R7: Code 010 replaces the byte with the A-law milliwatt sequence 34 21 21 34 B4 A1 A1 B4, indexed by the frame phase.
- R8: Code 011 replaces the byte with the mu-law milliwatt sequence 1E 0B 0B 1E 9E 8B 8B 9E, indexed by the frame phase.
- R9: Code 100 replaces the byte with the loopback input lpbk_data.
- R10: A nonzero glb_subst replaces the per-timeslot code for every timeslot. Inversion still follows the per-timeslot bits.
- R11: The bit inversion is applied after substitution. With bit 1 as the MSB (vector bit 7), control bit 4 flips the MSB (mask 80h), bit 3 flips bits 3, 5 and 7 (mask 2Ah), and bit 2 flips bits 2, 4, 6 and 8 (mask 55h). The three masks combine by OR.
- R12: The frame phase is 7 from reset until the first valid timeslot-0 byte. Each valid timeslot-0 byte advances the phase by one, wrapping after 7. The timeslot-0 byte and the rest of its frame use the new phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Indirect register write strobe |
| cfg_addr | input | 7 | Indirect register address |
| cfg_wdata | input | 8 | Indirect write data |
| cfg_rdata | output | 8 | Indirect read data, combinational from cfg_addr |
| glb_subst | input | 3 | Global substitution code; 000 defers to the per-timeslot code |
| in_valid | input | 1 | Input byte valid |
| in_ts | input | 5 | Timeslot index of the input byte |
| in_data | input | 8 | Input payload byte |
| lpbk_data | input | 8 | Loopback byte from the receive side |
| out_valid | output | 1 | Output byte valid |
| out_ts | output | 5 | Timeslot index of the output byte |
| out_data | output | 8 | Conditioned payload byte |

## Verification
The assertions assume that glb_subst and the register contents for the presented timeslot stay steady during the cycle a byte is accepted, and that in_ts is always below 32. The stimulus meets this by changing configuration only in cycles where in_valid is low. It also waits for each conditioned byte to be checked before it presents the next one. Milliwatt checks compute the expected phase from the number of timeslot-0 bytes sent since reset.

// File: rtl/tsc_pkg.sv
package tsc_pkg;

  localparam int BYTE_W  = 8;
  localparam int PHASE_W = 3;

  typedef enum logic [2:0] {
    SUB_PASS  = 3'b000,
    SUB_TRUNK = 3'b001,
    SUB_ALAW  = 3'b010,
    SUB_ULAW  = 3'b011,
    SUB_LOOP  = 3'b100
  } subst_e;

  // Bit 1 of a timeslot is the MSB (vector bit 7).
  localparam logic [7:0] MSK_MSB  = 8'h80;
  localparam logic [7:0] MSK_ODD  = 8'h2A;
  localparam logic [7:0] MSK_EVEN = 8'h55;

  function automatic logic [7:0] inv_mask(input logic msb, input logic odd, input logic even);
    logic [7:0] m;
    m = '0;
    if (msb)  m = m | MSK_MSB;
    if (odd)  m = m | MSK_ODD;
    if (even) m = m | MSK_EVEN;
    return m;
  endfunction

  function automatic logic [2:0] pick_subst(input logic [2:0] glb, input logic [2:0] local_sel);
    return (glb != 3'b000) ? glb : local_sel;
  endfunction

  function automatic logic [7:0] alaw_byte(input logic [2:0] ph);
    logic [7:0] b;
    case (ph[1:0])
      2'd0, 2'd3: b = 8'h34;
      default:    b = 8'h21;
    endcase
    if (ph[2]) b = b | 8'h80;
    if (ph[2] && (ph[1:0] == 2'd1 || ph[1:0] == 2'd2)) b = 8'hA1;
    return b;
  endfunction

  function automatic logic [7:0] ulaw_byte(input logic [2:0] ph);
    logic [7:0] b;
    case (ph[1:0])
      2'd0, 2'd3: b = 8'h1E;
      default:    b = 8'h0B;
    endcase
    if (ph[2]) b = b | 8'h80;
    return b;
  endfunction

endpackage

// File: rtl/tsc_bank.sv
module tsc_bank #(
  parameter int ENTRIES = 32,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [7:0]       wr_data,
  input  logic [IDX_W-1:0] lk_idx,
  output logic [7:0]       lk_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [7:0]       rd_data
);

  logic [7:0] mem_q [ENTRIES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) mem_q[i] <= '0;
    end else if (wr_en) begin
      mem_q[wr_idx] <= wr_data;
    end
  end

  assign lk_data = mem_q[lk_idx];
  assign rd_data = mem_q[rd_idx];

endmodule

// File: rtl/tsc_mw_gen.sv
module tsc_mw_gen #(
  parameter int TS_W = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [TS_W-1:0] in_ts,
  output logic            frame_tick,
  output logic [2:0]      phase_q,
  output logic [7:0]      alaw_cur,
  output logic [7:0]      ulaw_cur
);
  import tsc_pkg::*;

  logic [2:0] phase_use;

  assign frame_tick = in_valid && (in_ts == '0);
  assign phase_use  = frame_tick ? (phase_q + 3'd1) : phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          phase_q <= 3'd7;
    else if (frame_tick) phase_q <= phase_use;
  end

  assign alaw_cur = alaw_byte(phase_use);
  assign ulaw_cur = ulaw_byte(phase_use);

endmodule

// File: rtl/tsc_datapath.sv
module tsc_datapath #(
  parameter int TS_W = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [TS_W-1:0] in_ts,
  input  logic [7:0]      in_data,
  input  logic [7:0]      lpbk_data,
  input  logic [2:0]      glb_subst,
  input  logic [7:0]      ctrl_byte,
  input  logic [7:0]      trunk_byte,
  input  logic [7:0]      alaw_cur,
  input  logic [7:0]      ulaw_cur,
  output logic [2:0]      sel_code,
  output logic            out_valid,
  output logic [TS_W-1:0] out_ts,
  output logic [7:0]      out_data
);
  import tsc_pkg::*;

  logic [7:0] sub_byte;
  logic [7:0] xor_mask;

  assign sel_code = pick_subst(glb_subst, ctrl_byte[7:5]);
  assign xor_mask = inv_mask(ctrl_byte[4], ctrl_byte[3], ctrl_byte[2]);

  always_comb begin
    case (sel_code)
      SUB_TRUNK: sub_byte = trunk_byte;
      SUB_ALAW:  sub_byte = alaw_cur;
      SUB_ULAW:  sub_byte = ulaw_cur;
      SUB_LOOP:  sub_byte = lpbk_data;
      default:   sub_byte = in_data;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_ts    <= '0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_ts   <= in_ts;
        out_data <= sub_byte ^ xor_mask;
      end
    end
  end

endmodule

// File: rtl/tsc_payload_cond.sv
module tsc_payload_cond #(
  parameter int NUM_TS = 32,
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        cfg_rdata,
  input  logic [2:0]        glb_subst,
  input  logic              in_valid,
  input  logic [4:0]        in_ts,
  input  logic [7:0]        in_data,
  input  logic [7:0]        lpbk_data,
  output logic              out_valid,
  output logic [4:0]        out_ts,
  output logic [7:0]        out_data
);

  localparam int TS_W = $clog2(NUM_TS);
  localparam logic [ADDR_W-1:0] TRUNK_BASE = ADDR_W'(NUM_TS);
  localparam logic [ADDR_W-1:0] ADDR_END   = ADDR_W'(2 * NUM_TS);

  logic            ctrl_hit, trunk_hit;
  logic [TS_W-1:0] cfg_idx;
  logic [7:0]      ctrl_byte, trunk_byte, ctrl_rd, trunk_rd;
  logic            frame_tick;
  logic [2:0]      mw_phase;
  logic [7:0]      alaw_cur, ulaw_cur;
  logic [2:0]      sel_code;

  assign ctrl_hit  = cfg_addr < TRUNK_BASE;
  assign trunk_hit = (cfg_addr >= TRUNK_BASE) && (cfg_addr < ADDR_END);
  assign cfg_idx   = cfg_addr[TS_W-1:0];

  tsc_bank #(.ENTRIES(NUM_TS), .IDX_W(TS_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .wr_en(cfg_we && ctrl_hit), .wr_idx(cfg_idx), .wr_data(cfg_wdata),
    .lk_idx(in_ts[TS_W-1:0]), .lk_data(ctrl_byte),
    .rd_idx(cfg_idx), .rd_data(ctrl_rd)
  );

  tsc_bank #(.ENTRIES(NUM_TS), .IDX_W(TS_W)) u_trunk (
    .clk(clk), .rst_n(rst_n),
    .wr_en(cfg_we && trunk_hit), .wr_idx(cfg_idx), .wr_data(cfg_wdata),
    .lk_idx(in_ts[TS_W-1:0]), .lk_data(trunk_byte),
    .rd_idx(cfg_idx), .rd_data(trunk_rd)
  );

  assign cfg_rdata = ctrl_hit ? ctrl_rd : (trunk_hit ? trunk_rd : 8'h00);

  tsc_mw_gen #(.TS_W(5)) u_mw (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ts(in_ts),
    .frame_tick(frame_tick), .phase_q(mw_phase),
    .alaw_cur(alaw_cur), .ulaw_cur(ulaw_cur)
  );

  tsc_datapath #(.TS_W(5)) u_dp (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ts(in_ts),
    .in_data(in_data), .lpbk_data(lpbk_data), .glb_subst(glb_subst),
    .ctrl_byte(ctrl_byte), .trunk_byte(trunk_byte),
    .alaw_cur(alaw_cur), .ulaw_cur(ulaw_cur), .sel_code(sel_code),
    .out_valid(out_valid), .out_ts(out_ts), .out_data(out_data)
  );

endmodule

// File: rtl/tsc_payload_cond_chk.sv
module tsc_payload_cond_chk #(
  parameter int NUM_TS = 32,
  parameter int ADDR_W = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] cfg_addr,
  input logic [7:0]        cfg_rdata,
  input logic [2:0]        glb_subst,
  input logic              in_valid,
  input logic [4:0]        in_ts,
  input logic [7:0]        in_data,
  input logic [7:0]        lpbk_data,
  input logic              out_valid,
  input logic [4:0]        out_ts,
  input logic [7:0]        out_data,
  input logic [7:0]        ctrl_byte,
  input logic [7:0]        trunk_byte,
  input logic              frame_tick,
  input logic [2:0]        mw_phase
);

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R4
  AST_IDLE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R4
  AST_TS_CARRIED: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (out_ts == $past(in_ts))); // R4
  AST_BAD_ADDR_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_addr >= ADDR_W'(2 * NUM_TS)) |-> (cfg_rdata == 8'h00)); // R3
  AST_PLAIN_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && glb_subst == 3'b000 && ctrl_byte == 8'h00) |=> (out_data == $past(in_data))); // R5
  AST_LOOP_PICK: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && glb_subst == 3'b100 && ctrl_byte[4:2] == 3'b000) |=> (out_data == $past(lpbk_data))); // R10
  AST_GLB_TRUNK: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && glb_subst == 3'b001 && ctrl_byte[4:2] == 3'b000) |=> (out_data == $past(trunk_byte))); // R10
  AST_FULL_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && glb_subst == 3'b000 && ctrl_byte == 8'h1C) |=> (out_data == ~$past(in_data))); // R11
  AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    frame_tick |=> (mw_phase == $past(mw_phase) + 3'd1)); // R12
  AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_tick |=> $stable(mw_phase)); // R12

endmodule

bind tsc_payload_cond tsc_payload_cond_chk #(.NUM_TS(NUM_TS), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_rdata(cfg_rdata),
  .glb_subst(glb_subst), .in_valid(in_valid), .in_ts(in_ts), .in_data(in_data),
  .lpbk_data(lpbk_data), .out_valid(out_valid), .out_ts(out_ts), .out_data(out_data),
  .ctrl_byte(ctrl_byte), .trunk_byte(trunk_byte),
  .frame_tick(frame_tick), .mw_phase(mw_phase)
);

// File: tb/sim_tsc_payload_cond.sv
`timescale 1ns/1ps
module sim_tsc_payload_cond;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [6:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] cfg_rdata;
  logic [2:0] glb_subst = '0;
  logic       in_valid = 1'b0;
  logic [4:0] in_ts = '0;
  logic [7:0] in_data = '0;
  logic [7:0] lpbk_data = '0;
  logic       out_valid;
  logic [4:0] out_ts;
  logic [7:0] out_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  tsc_payload_cond u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .glb_subst(glb_subst),
    .in_valid(in_valid), .in_ts(in_ts), .in_data(in_data), .lpbk_data(lpbk_data),
    .out_valid(out_valid), .out_ts(out_ts), .out_data(out_data)
  );

  // Vector: ctrl, trunk, glb, ts, din, lpbk, expected
  localparam int NV = 18;
  localparam logic [55:0] VEC [NV] = '{
    {8'h00, 8'h00, 8'd0, 8'd3,  8'h5A, 8'h00, 8'h5A}, // R5 pass
    {8'h20, 8'hC3, 8'd0, 8'd4,  8'h11, 8'h00, 8'hC3}, // R6 trunk
    {8'h40, 8'h00, 8'd0, 8'd5,  8'h11, 8'h00, 8'hB4}, // R7 A-law phase 7
    {8'h60, 8'h00, 8'd0, 8'd6,  8'h11, 8'h00, 8'h9E}, // R8 mu-law phase 7
    {8'h80, 8'h00, 8'd0, 8'd7,  8'h11, 8'h77, 8'h77}, // R9 loopback
    {8'hA0, 8'h00, 8'd0, 8'd8,  8'h3C, 8'h00, 8'h3C}, // R5 reserved 101
    {8'hE0, 8'h00, 8'd0, 8'd9,  8'h3C, 8'h00, 8'h3C}, // R5 reserved 111
    {8'h04, 8'h00, 8'd0, 8'd10, 8'h00, 8'h00, 8'h55}, // R11 even
    {8'h08, 8'h00, 8'd0, 8'd11, 8'h00, 8'h00, 8'h2A}, // R11 odd w/o MSB
    {8'h0C, 8'h00, 8'd0, 8'd12, 8'hFF, 8'h00, 8'h80}, // R11 bits 2..8
    {8'h10, 8'h00, 8'd0, 8'd13, 8'h00, 8'h00, 8'h80}, // R11 MSB
    {8'h14, 8'h00, 8'd0, 8'd14, 8'h00, 8'h00, 8'hD5}, // R11 MSB+even
    {8'h18, 8'h00, 8'd0, 8'd15, 8'h00, 8'h00, 8'hAA}, // R11 all odd
    {8'h1C, 8'h00, 8'd0, 8'd16, 8'hA5, 8'h00, 8'h5A}, // R11 all
    {8'h24, 8'h0F, 8'd0, 8'd17, 8'h99, 8'h00, 8'h5A}, // R11 after subst
    {8'h00, 8'h99, 8'd1, 8'd20, 8'h12, 8'h00, 8'h99}, // R10 global trunk
    {8'h20, 8'h33, 8'd4, 8'd21, 8'h12, 8'h44, 8'h44}, // R10 global loop
    {8'h1C, 8'h00, 8'd3, 8'd22, 8'h00, 8'h00, 8'h61}  // R10 global mu + inv
  };

  localparam logic [7:0] A_SEQ [8] = '{8'h34, 8'h21, 8'h21, 8'h34, 8'hB4, 8'hA1, 8'hA1, 8'hB4};
  localparam logic [7:0] U_SEQ [8] = '{8'h1E, 8'h0B, 8'h0B, 8'h1E, 8'h9E, 8'h8B, 8'h8B, 8'h9E};

  task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd_chk(input logic [6:0] a, input logic [7:0] exp, input string req);
    @(negedge clk);
    cfg_addr = a;
    #1;
    chk(cfg_rdata == exp, req, cfg_rdata, exp);
  endtask

  task automatic send(input logic [4:0] ts, input logic [7:0] d, input logic [7:0] lp,
                      input logic [7:0] exp, input string req);
    @(negedge clk);
    in_valid = 1'b1; in_ts = ts; in_data = d; lpbk_data = lp;
    @(posedge clk);
    #1;
    chk(out_data == exp, req, out_data, exp);
    chk(out_valid && out_ts == ts, "R4", {3'b0, out_ts}, {3'b0, ts});
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(out_valid == 1'b0, "R1", {7'b0, out_valid}, 8'h00);
    chk(out_data == 8'h00, "R1", out_data, 8'h00);
    rd_chk(7'h00, 8'h00, "R1");
    rd_chk(7'h3F, 8'h00, "R1");

    for (int i = 0; i < NV; i++) begin
      logic [7:0] c, t, g, ts, d, lp, e;
      {c, t, g, ts, d, lp, e} = VEC[i];
      wr(ts[6:0], c);
      wr(7'h20 + ts[6:0], t);
      glb_subst = g[2:0];
      rd_chk(ts[6:0], c, "R2");
      rd_chk(7'h20 + ts[6:0], t, "R2");
      send(ts[4:0], d, lp, e, "R5-R11 table");
    end
    glb_subst = 3'b000;

    // R4: idle cycle gives no valid
    @(negedge clk);
    @(posedge clk);
    #1;
    chk(out_valid == 1'b0, "R4", {7'b0, out_valid}, 8'h00);

    // R3: out-of-range writes ignored, reads zero
    wr(7'h45, 8'hFF);
    wr(7'h7F, 8'hFF);
    wr(7'h40, 8'hFF);
    rd_chk(7'h45, 8'h00, "R3");
    rd_chk(7'h40, 8'h00, "R3");
    rd_chk(7'h05, 8'h40, "R3");
    rd_chk(7'h1F, 8'h00, "R3");
    rd_chk(7'h00, 8'h00, "R3");
    send(5'd5, 8'h00, 8'h00, 8'hB4, "R3");

    // R12: phase advance per frame, shared within a frame, wrap
    wr(7'h00, 8'h40);
    wr(7'h01, 8'h40);
    for (int k = 0; k < 9; k++) begin
      send(5'd0, 8'h00, 8'h00, A_SEQ[k % 8], "R12");
      send(5'd1, 8'h00, 8'h00, A_SEQ[k % 8], "R7");
    end
    glb_subst = 3'b011;
    send(5'd0, 8'h00, 8'h00, U_SEQ[1], "R8");
    send(5'd1, 8'h00, 8'h00, U_SEQ[1], "R12");
    glb_subst = 3'b000;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule